// File: doc/BRIEF.md
# Audio Channel Interrupt Status Aggregator

This block gathers end-of-buffer events from two playback channels and one capture channel and turns them into a 32-bit status word and one level-sensitive interrupt line. Each channel has a pending flag. A terminal-count pulse on that channel's input sets the flag, but only if the channel's interrupt enable is set in the current serial-control word. Software drops a pending flag by writing a serial-control value that turns that channel's interrupt enable off. Writing a one to the status word does not clear it.

The block also works out, from the control word and the serial-control word, whether each channel may move data. It drives one run-enable per channel. The DMA engines that serve the channels use these enables.

Every output is registered. An input seen at one clock edge shows up on the outputs after that edge.

Top module: `aud_irq_status`

## Requirements
- R1: Status bit 0 holds the capture pending flag, bit 1 holds the second playback channel's flag and bit 2 holds the first playback channel's flag. Bits 4:3, 30:7 and bit 7 upward, other than bit 31, read as zero. The terminal-count input uses the same order: tc_pulse_i[0] is capture, [1] is the second playback channel and [2] is the first playback channel.
- R2: Status bit 31 and irq_o both equal the OR of the three pending flags, in every cycle.
- R3: Status bits 6:5 always read as 3, so the word reads 0x60 when nothing is pending.
- R4: A terminal-count pulse sets its flag at the next clock edge only when the channel's interrupt enable is 1 in sctl_cur_i. The enables are bit 8 for the first playback channel, bit 9 for the second playback channel and bit 10 for capture.
- R5: A pending flag stays set until it is cleared. A write whose data keeps the enable at 1, a write that raises the enable from 0 to 1, and data presented while sctl_wr_i is low all leave the flag unchanged.
- R6: A write (sctl_wr_i high) clears a channel's flag at the next edge when its enable bit is 1 in sctl_cur_i and 0 in sctl_wdata_i.
- R7: If a clearing write and a terminal-count pulse reach the same channel in the same cycle, the flag ends up clear.
- R8: run_o is registered one cycle after its inputs. run_o[2] = ctl bit 6 AND NOT sctl bit 11. run_o[1] = ctl bit 5 AND NOT sctl bit 12. run_o[0] = ctl bit 4; capture has no pause bit.
- R9: While rst_i is high, all flags are zero, irq_o is low, status reads 0x00000060 and run_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ctl_i | input | 32 | Current control word |
| sctl_cur_i | input | 32 | Current serial-control word |
| sctl_wr_i | input | 1 | Serial-control write strobe |
| sctl_wdata_i | input | 32 | Serial-control value being written |
| tc_pulse_i | input | 3 | Terminal-count pulses, ordered as the status bits |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Level interrupt, OR of the pending flags |
| run_o | output | 3 | Per-channel run enables, ordered as the status bits |

## Verification
Each pending flag drives its own status bit directly, so a wrong flag shows on status_o one edge after the pulse or write that caused it. The same edge shows the error on bit 31 and on irq_o. If the set and clear priority is wrong, a set flag remains where the bench expects a clear bit. A wrong enable or pause bit position shows on run_o one edge after the control words change.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int CH_N       = 3;
  localparam int WORD_W     = 32;
  localparam int SUMMARY_IX = WORD_W - 1;
  localparam logic [WORD_W-1:0] VOICE_IDLE = 32'h0000_0060;

  // Channel index k follows the status bit order:
  // 0 = capture, 1 = second playback, 2 = first playback
  function automatic int ie_pos(input int k);
    case (k)
      0:       return 10;
      1:       return 9;
      default: return 8;
    endcase
  endfunction

  function automatic int en_pos(input int k);
    case (k)
      0:       return 4;
      1:       return 5;
      default: return 6;
    endcase
  endfunction

  function automatic bit has_pause(input int k);
    return (k != 0);
  endfunction

  function automatic int pause_pos(input int k);
    case (k)
      1:       return 12;
      2:       return 11;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/aud_pend_cell.sv
module aud_pend_cell #(
  parameter int W      = 32,
  parameter int IE_BIT = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] sctl_cur_i,
  input  logic         sctl_wr_i,
  input  logic [W-1:0] sctl_wdata_i,
  input  logic         tc_i,
  output logic         pend_q,
  output logic         pend_nxt
);
  logic ie_now, clr_hit, set_hit;

  assign ie_now  = sctl_cur_i[IE_BIT];
  assign clr_hit = sctl_wr_i & ie_now & ~sctl_wdata_i[IE_BIT];
  assign set_hit = tc_i & ie_now;

  always_comb begin
    pend_nxt = pend_q;
    if (clr_hit)      pend_nxt = 1'b0;
    else if (set_hit) pend_nxt = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q <= 1'b0;
    else       pend_q <= pend_nxt;
  end

  AST_CLEAR_BEATS_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (sctl_wr_i && sctl_cur_i[IE_BIT] && !sctl_wdata_i[IE_BIT]) |=> !pend_q); // R7
  AST_SET_WHEN_ENABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (tc_i && sctl_cur_i[IE_BIT] && !(sctl_wr_i && !sctl_wdata_i[IE_BIT])) |=> pend_q); // R4
  AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pend_q && !sctl_cur_i[IE_BIT]) |=> !pend_q); // R4
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_q && !sctl_wr_i) |=> pend_q); // R5
endmodule

// File: rtl/aud_run_gate.sv
module aud_run_gate
  import aud_irq_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = CH_N
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] ctl_i,
  input  logic [W-1:0] sctl_i,
  output logic [N-1:0] run_q
);
  logic [N-1:0] want;

  for (genvar k = 0; k < N; k++) begin : g_ch
    if (has_pause(k)) begin : g_pause
      assign want[k] = ctl_i[en_pos(k)] & ~sctl_i[pause_pos(k)];
    end else begin : g_nopause
      assign want[k] = ctl_i[en_pos(k)];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) run_q <= '0;
    else       run_q <= want;
  end

  AST_RUN_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (run_q == $past(want))); // R8
  AST_RUN_NEEDS_CTL: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctl_i[en_pos(0)] |=> !run_q[0]); // R8
endmodule

// File: rtl/aud_irq_status.sv
module aud_irq_status
  import aud_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [WORD_W-1:0] ctl_i,
  input  logic [WORD_W-1:0] sctl_cur_i,
  input  logic              sctl_wr_i,
  input  logic [WORD_W-1:0] sctl_wdata_i,
  input  logic [CH_N-1:0]   tc_pulse_i,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o,
  output logic [CH_N-1:0]   run_o
);
  logic [CH_N-1:0] pend_q, pend_nxt;
  logic            irq_q;

  for (genvar k = 0; k < CH_N; k++) begin : g_pend
    aud_pend_cell #(.W(WORD_W), .IE_BIT(ie_pos(k))) u_cell (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .sctl_cur_i  (sctl_cur_i),
      .sctl_wr_i   (sctl_wr_i),
      .sctl_wdata_i(sctl_wdata_i),
      .tc_i        (tc_pulse_i[k]),
      .pend_q      (pend_q[k]),
      .pend_nxt    (pend_nxt[k])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |pend_nxt;
  end

  aud_run_gate #(.W(WORD_W), .N(CH_N)) u_run (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ctl_i (ctl_i),
    .sctl_i(sctl_cur_i),
    .run_q (run_o)
  );

  always_comb begin
    status_o = VOICE_IDLE;
    status_o[CH_N-1:0] = pend_q;
    status_o[SUMMARY_IX] = irq_q;
  end
  assign irq_o = irq_q;

  AST_IRQ_IS_OR: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == (|status_o[CH_N-1:0])); // R2
  AST_VOICE_FIELD: assert property (@(posedge clk_i)
    status_o[6:5] == 2'b11); // R3
  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    rst_i |=> (status_o[CH_N-1:0] == '0)); // R9
endmodule

// File: tb/aud_irq_status_test.sv
module aud_irq_status_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ctl, sctl, wdata;
  logic        wr;
  logic [2:0]  tc;
  logic [31:0] status;
  logic        irq;
  logic [2:0]  run;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aud_irq_status uut (
    .clk_i(clk), .rst_i(rst), .ctl_i(ctl), .sctl_cur_i(sctl),
    .sctl_wr_i(wr), .sctl_wdata_i(wdata), .tc_pulse_i(tc),
    .status_o(status), .irq_o(irq), .run_o(run)
  );

  // ctl, sctl, wr, wdata, tc, exp_pend, exp_run
  typedef struct packed {
    logic [31:0] c; logic [31:0] s; logic w; logic [31:0] d;
    logic [2:0] t; logic [2:0] p; logic [2:0] r;
  } vec_t;
  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{32'h00, 32'h0000, 1'b0, 32'h0, 3'b111, 3'b000, 3'b000}, // R4 disabled
    '{32'h00, 32'h0700, 1'b0, 32'h0, 3'b001, 3'b001, 3'b000}, // R4 R1 capture
    '{32'h00, 32'h0700, 1'b0, 32'h0, 3'b110, 3'b111, 3'b000}, // R4 R1 playback
    '{32'h00, 32'h0700, 1'b0, 32'h0, 3'b000, 3'b111, 3'b000}, // R5 hold
    '{32'h70, 32'h0700, 1'b0, 32'h0, 3'b000, 3'b111, 3'b111}, // R8 all run
    '{32'h70, 32'h1F00, 1'b0, 32'h0, 3'b000, 3'b111, 3'b001}, // R8 both paused
    '{32'h70, 32'h0F00, 1'b0, 32'h0, 3'b000, 3'b111, 3'b011}, // R8 first paused
    '{32'h70, 32'h0700, 1'b1, 32'h0300, 3'b000, 3'b110, 3'b111}, // R6 capture clr
    '{32'h70, 32'h0700, 1'b1, 32'h0500, 3'b010, 3'b100, 3'b111}, // R7 clear wins
    '{32'h40, 32'h0400, 1'b1, 32'h0700, 3'b000, 3'b100, 3'b100}, // R5 raise no clr
    '{32'h20, 32'h0100, 1'b1, 32'h0000, 3'b000, 3'b000, 3'b010}, // R6 play1 clr
    '{32'h10, 32'h0400, 1'b0, 32'h0, 3'b001, 3'b001, 3'b001}, // R4 set again
    '{32'h10, 32'h0400, 1'b1, 32'h0400, 3'b000, 3'b001, 3'b001}, // R5 kept at 1
    '{32'h00, 32'h0400, 1'b0, 32'h0000, 3'b000, 3'b001, 3'b000}, // R5 no strobe
    '{32'h00, 32'h0000, 1'b0, 32'h0, 3'b000, 3'b001, 3'b000}  // R4 R5 hold
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    ctl = v.c; sctl = v.s; wr = v.w; wdata = v.d; tc = v.t;
    @(posedge clk); #1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; ctl = 0; sctl = 0; wr = 0; wdata = 0; tc = 0;
    repeat (2) @(posedge clk); #1;
    check32("R9 status", status, 32'h60);
    check32("R9 irq", {31'b0, irq}, 32'h0);
    check32("R9 run", {29'b0, run}, 32'h0);
    @(negedge clk); rst = 0;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] es;
      step(VT[i]);
      es = 32'h60 | {29'b0, VT[i].p} | ((|VT[i].p) ? 32'h8000_0000 : 32'h0);
      check32($sformatf("R1 R3 status v%0d", i), status, es);
      check32($sformatf("R2 irq v%0d", i), {31'b0, irq}, {31'b0, |VT[i].p});
      check32($sformatf("R8 run v%0d", i), {29'b0, run}, {29'b0, VT[i].r});
    end
    // R9: reset mid-operation clears pending and run
    step('{32'h70, 32'h0700, 1'b0, 32'h0, 3'b111, 3'b111, 3'b111});
    check32("R2 irq before reset", {31'b0, irq}, 32'h1);
    @(negedge clk); rst = 1; tc = 3'b111;
    @(posedge clk); #1;
    check32("R9 status mid", status, 32'h60);
    check32("R9 run mid", {29'b0, run}, 32'h0);
    @(negedge clk); rst = 0; tc = 0; ctl = 0; sctl = 0;
    @(posedge clk); #1;
    check32("R3 idle word", status, 32'h60);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule